// File: doc/BRIEF.md
# Rotating Shared Tile Buffer Controller

This block sequences a ring of processing tiles that cooperate on one layer. Each tile's buffer holds one slice of the data that all tiles need, for example a weight group or an input feature map group. Every slice exists in exactly one buffer at a time. Tile x works on slice (x + t) mod N at step t, so the tiles start together on different slices. After every step each buffer takes over the slice held by its ring neighbour. After N steps every tile has used every slice.

A pass begins with `start`. The controller asks external memory to fill each tile's buffer with its first slice. Once all loads are acknowledged, it fires a step start to every tile in the same cycle. It then waits until every tile has reported the end of its step, rotates the slices and starts the next step. After the last step it pulses `pass_done`. A sticky `err` flag records a rotation that fired while any tile still reported itself busy. The compute inside the tiles is not modelled; only slice identifiers, handshakes and the step sequence are.

Top module: `rot_buf_ctrl`

## Requirements
- R1: After reset, `tile_go`, `mem_req`, `rotate`, `pass_done` and `err` are all 0, and tile x holds slice ID x.
- R2: The cycle after `start` is taken while idle, `mem_req` is all ones and the field `mem_req_id[x*SW +: SW]` equals x for every tile x.
- R3: A tile's `mem_req` bit drops after its `mem_ack`. No step starts until every tile has been acknowledged, and the acks may arrive in different cycles.
- R4: The first cycle after the last acknowledgement has every bit of `tile_go` high in that single cycle. `step_idx` is 0 and tile x shows slice x.
- R5: When `tile_go` is high for step t, tile x shows slice (x + t) mod N in `tile_slice[x*SW +: SW]`, and no two tiles show the same slice.
- R6: A rotation happens only after every tile has pulsed `step_done` for the current step, and the pulses may come in different cycles. The cycle after the last pulse shows `rotate`, all `tile_go` bits high, `step_idx` one higher, and each tile holding the slice that its neighbour x+1 held before.
- R7: After the step_done pulses of step N-1 complete, the next cycle shows a single-cycle `pass_done` with no `tile_go` and no `rotate`. The block then returns to idle.
- R8: If any `tile_busy` bit is high in the cycle a rotation is triggered, `err` is 1 from the next cycle on. It stays set until the next `start` clears it.
- R9: `mem_req` is 0 in every cycle while steps are running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (taken while idle) |
| mem_req | output | N | Per-tile buffer fill request to memory |
| mem_req_id | output | N*SW | Slice ID requested for each tile |
| mem_ack | input | N | Per-tile fill acknowledge |
| tile_go | output | N | Step start pulse, one bit per tile |
| tile_slice | output | N*SW | Slice ID currently buffered by each tile |
| tile_busy | input | N | Tile reports it is still computing |
| step_done | input | N | Tile reports end of its current step (pulse) |
| rotate | output | 1 | Pulse: buffers have shifted one place along the ring |
| step_idx | output | SW | Index of the current step |
| pass_done | output | 1 | Pulse after the last step of a pass |
| err | output | 1 | Sticky: rotation fired with a tile busy |

## Verification
The bench builds the block with four tiles. With four tiles the slice IDs are two bits wide and the wrap from ID 3 back to ID 0 happens inside one pass, so every step of the skew modulo N is visible. It staggers load acknowledgements and step_done pulses over different cycles to show that nothing advances early. It holds one tile busy at a rotation to set the error flag and then starts a second pass to clear it.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN} rbc_state_e;
endpackage

// File: rtl/rbc_collect.sv
// Collects one handshake pulse per tile; all_o is high once every tile has reported.
module rbc_collect #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] hit,
  output logic         all_o
);
  logic [N-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst || clr) seen_q <= '0;
    else            seen_q <= seen_q | hit;
  end

  assign all_o = &(seen_q | hit);
endmodule

// File: rtl/rbc_ring.sv
// One slice-ID register per tile buffer; a shift moves each slice one place along the ring.
module rbc_ring #(
  parameter int N  = 4,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          shift,
  output logic [N*SW-1:0] slices
);
  logic [SW-1:0] slot_q [N];

  for (genvar x = 0; x < N; x++) begin : g_slot
    localparam int NEXT = (x + 1) % N;
    always_ff @(posedge clk) begin
      if (rst || init) slot_q[x] <= SW'(x);
      else if (shift)  slot_q[x] <= slot_q[NEXT];
    end
    assign slices[x*SW +: SW] = slot_q[x];

    for (genvar y = x + 1; y < N; y++) begin : g_pair
      // R5: a slice never sits in two buffers at once
      p_unique_r5: assert property (@(posedge clk) disable iff (rst)
        slot_q[x] != slot_q[y]);
    end
  end
endmodule

// File: rtl/rbc_seq.sv
// Pass sequencer: load, simultaneous step start, wait for all tiles, rotate, finish.
module rbc_seq
  import rbc_pkg::*;
#(
  parameter int N  = 4,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [N-1:0]  mem_ack,
  input  logic          ack_all,
  input  logic          done_all,
  input  logic [N-1:0]  tile_busy,
  output logic [N-1:0]  mem_req,
  output logic [N-1:0]  tile_go,
  output logic          rotate,
  output logic          pass_done,
  output logic          err,
  output logic [SW-1:0] step_q,
  output logic          ring_init,
  output logic          ring_shift,
  output logic          ack_clr,
  output logic          done_clr
);
  localparam logic [SW-1:0] LAST = SW'(N - 1);

  rbc_state_e state_q;
  logic       last_step;

  assign last_step  = (step_q == LAST);
  assign ring_init  = (state_q == S_IDLE) && start;
  assign ring_shift = (state_q == S_RUN) && done_all && !last_step;
  assign ack_clr    = (state_q != S_LOAD) || ack_all;
  assign done_clr   = (state_q != S_RUN) || done_all;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      mem_req   <= '0;
      tile_go   <= '0;
      rotate    <= 1'b0;
      pass_done <= 1'b0;
      err       <= 1'b0;
      step_q    <= '0;
    end else begin
      tile_go   <= '0;
      rotate    <= 1'b0;
      pass_done <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_LOAD;
          mem_req <= '1;
          err     <= 1'b0;
          step_q  <= '0;
        end
        S_LOAD: begin
          mem_req <= mem_req & ~mem_ack;
          if (ack_all) begin
            state_q <= S_RUN;
            mem_req <= '0;
            tile_go <= '1;
          end
        end
        S_RUN: if (done_all) begin
          if (last_step) begin
            state_q   <= S_IDLE;
            pass_done <= 1'b1;
          end else begin
            rotate  <= 1'b1;
            tile_go <= '1;
            step_q  <= step_q + 1'b1;
            if (|tile_busy) err <= 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R9: memory is only asked for buffer fills while loading
  p_req_in_load_r9: assert property (@(posedge clk) disable iff (rst)
    (|mem_req) |-> (state_q == S_LOAD));
  // R7: the pass ends on the final step index
  p_pass_last_r7: assert property (@(posedge clk) disable iff (rst)
    pass_done |-> (step_q == LAST) && (tile_go == '0));
  // R8: once set, the error flag holds until a new pass is started
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(err) && !$past(ring_init)) |-> err);
endmodule

// File: rtl/rot_buf_ctrl.sv
module rot_buf_ctrl #(
  parameter int N  = 4,
  parameter int SW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic [N-1:0]    mem_req,
  output logic [N*SW-1:0] mem_req_id,
  input  logic [N-1:0]    mem_ack,
  output logic [N-1:0]    tile_go,
  output logic [N*SW-1:0] tile_slice,
  input  logic [N-1:0]    tile_busy,
  input  logic [N-1:0]    step_done,
  output logic            rotate,
  output logic [SW-1:0]   step_idx,
  output logic            pass_done,
  output logic            err
);
  logic ack_all, done_all, ring_init, ring_shift, ack_clr, done_clr;

  rbc_collect #(.N(N)) u_ack (
    .clk(clk), .rst(rst), .clr(ack_clr), .hit(mem_ack & mem_req), .all_o(ack_all));

  rbc_collect #(.N(N)) u_done (
    .clk(clk), .rst(rst), .clr(done_clr), .hit(step_done), .all_o(done_all));

  rbc_ring #(.N(N), .SW(SW)) u_ring (
    .clk(clk), .rst(rst), .init(ring_init), .shift(ring_shift), .slices(tile_slice));

  rbc_seq #(.N(N), .SW(SW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .mem_ack(mem_ack), .ack_all(ack_all),
    .done_all(done_all), .tile_busy(tile_busy), .mem_req(mem_req), .tile_go(tile_go),
    .rotate(rotate), .pass_done(pass_done), .err(err), .step_q(step_idx),
    .ring_init(ring_init), .ring_shift(ring_shift), .ack_clr(ack_clr), .done_clr(done_clr));

  // The first fill of a pass always requests the slice the tile starts on.
  assign mem_req_id = tile_slice;

  // R4: every tile starts a step in the same cycle
  p_go_together_r4: assert property (@(posedge clk) disable iff (rst)
    (|tile_go) |-> (&tile_go));

  for (genvar x = 0; x < N; x++) begin : g_skew
    // R5: skewed order, tile x on slice (x + t) mod N at step t
    p_skew_r5: assert property (@(posedge clk) disable iff (rst)
      tile_go[x] |-> (tile_slice[x*SW +: SW] == SW'((x + int'(step_idx)) % N)));
  end
endmodule

// File: tb/rot_buf_ctrl_test.sv
`timescale 1ns/1ps
module rot_buf_ctrl_test;
  localparam int N  = 4;
  localparam int SW = 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [N-1:0] mem_req, mem_ack = '0, tile_go, tile_busy = '0, step_done = '0;
  logic [N*SW-1:0] mem_req_id, tile_slice;
  logic rotate, pass_done, err;
  logic [SW-1:0] step_idx;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rot_buf_ctrl #(.N(N), .SW(SW)) uut (
    .clk(clk), .rst(rst), .start(start), .mem_req(mem_req), .mem_req_id(mem_req_id),
    .mem_ack(mem_ack), .tile_go(tile_go), .tile_slice(tile_slice), .tile_busy(tile_busy),
    .step_done(step_done), .rotate(rotate), .step_idx(step_idx),
    .pass_done(pass_done), .err(err));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N*SW-1:0] skew(input int t);
    logic [N*SW-1:0] v;
    for (int x = 0; x < N; x++) v[x*SW +: SW] = SW'((x + t) % N);
    return v;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 go", tile_go, 0);
    check("R1 req", mem_req, 0);
    check("R1 flags", {rotate, pass_done, err}, 0);
    check("R1 slices", tile_slice, skew(0));
  endtask

  task automatic t_load();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 req", mem_req, 4'hF);
    check("R2 ids", mem_req_id, skew(0));
    mem_ack = 4'b0001;
    @(negedge clk);
    mem_ack = '0;
    check("R3 req drop", mem_req, 4'b1110);
    check("R3 no go", tile_go, 0);
    mem_ack = 4'b0100;
    @(negedge clk);
    check("R3 still no go", tile_go, 0);
    mem_ack = 4'b1010;
    @(negedge clk);
    mem_ack = '0;
    check("R4 go all", tile_go, 4'hF);
    check("R4 step", step_idx, 0);
    check("R4 slices", tile_slice, skew(0));
    check("R9 no req", mem_req, 0);
    @(negedge clk);
    check("R4 go single", tile_go, 0);
  endtask

  // Each tile pulses step_done in cycle d[x]; stuck tiles report busy throughout.
  task automatic do_step(input int t, input int d[N], input logic [N-1:0] stuck);
    int mx = 0;
    for (int x = 0; x < N; x++) if (d[x] > mx) mx = d[x];
    for (int c = 1; c <= mx; c++) begin
      for (int x = 0; x < N; x++) begin
        step_done[x] = (c == d[x]);
        tile_busy[x] = (c < d[x]) || stuck[x];
      end
      @(negedge clk);
      if (c < mx) check("R6 waits for all", {tile_go, rotate}, 0);
      check("R9 no req run", mem_req, 0);
    end
    step_done = '0;
    tile_busy = '0;
    if (t < N - 1) begin
      check("R6 rotate", rotate, 1);
      check("R6 go", tile_go, 4'hF);
      check("R6 step", step_idx, t + 1);
      check("R5 skew", tile_slice, skew(t + 1));
    end else begin
      check("R7 pass_done", pass_done, 1);
      check("R7 no go", {tile_go, rotate}, 0);
    end
    @(negedge clk);
  endtask

  task automatic t_pass();
    do_step(0, '{1, 3, 2, 4}, '0);
    do_step(1, '{2, 2, 2, 2}, '0);
    do_step(2, '{5, 1, 1, 3}, '0);
    do_step(3, '{1, 2, 3, 1}, '0);
    check("R7 single pulse", pass_done, 0);
    check("R8 no err", err, 0);
  endtask

  task automatic t_err();
    t_load();
    do_step(0, '{1, 1, 1, 1}, 4'b0100);
    check("R8 err set", err, 1);
    do_step(1, '{1, 2, 1, 1}, '0);
    check("R8 err held", err, 1);
    do_step(2, '{1, 1, 1, 1}, '0);
    do_step(3, '{2, 1, 1, 1}, '0);
    check("R8 err idle", err, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 err cleared", err, 0);
    mem_ack = 4'hF;
    @(negedge clk);
    mem_ack = '0;
    check("R4 go again", tile_go, 4'hF);
  endtask

  initial begin
    #900000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_pass();
    t_err();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule